// File: doc/BRIEF.md
# Raster-Op Blend Unit with Edge Masks

This block merges a source word with a destination word through any one of the sixteen two-input Boolean functions. The function is chosen by four minterm enable bits. Optional left and right edge masks then restore the destination value in bits that lie outside the target rectangle. The source normally comes from an internal first-in first-out queue of source words, which an upstream shifter fills. In line-draw mode the source is instead one pixel bit copied into every position of the word.

The masked result is held in a result latch and can also be written back into the queue, so one pass can feed the next. The word read port returns either the result latch or the latch that holds the last popped source word. A separate single-bit port returns one pixel of the result, addressed from the most significant end.

Top module: `rop_blend_unit`

## Requirements
- R1: For source S and destination D, the result before masking is (F3&S&D)|(F2&S&~D)|(F1&~S&D)|(F0&~S&~D). F3..F0 are bits 15..12 of the control word, and each one applies to every bit position.
- R2: A pulse on ctrl_we_i loads the control word. The left-mask count is bits 7:4, the right-mask count is bits 3:0, and bits 11:8 have no effect on the result. After reset the control word is zero.
- R3: When line mode is off, each destination write pops the oldest queued source word, uses it as S, and captures it in the source latch. Words leave the queue in the order they were pushed through src_push_i.
- R4: When line mode is on, S is all ones if pixel_i is high and all zeros if it is low. No word is popped, and the source latch keeps its value.
- R5: When lmask_en_i is high, the left mask is all ones shifted right, with zero fill, by the left count. Result bits where this mask is 0 take the destination value. When lmask_en_i is low the left count has no effect.
- R6: When rmask_en_i is high, the right mask is 0x8000 shifted right by the right count, with ones filled in from the top. Result bits where this mask is 0 take the destination value. When rmask_en_i is low the right count has no effect.
- R7: When both masks are enabled, only bits that are 1 in both masks take the computed value. All other bits keep the destination.
- R8: When dst_wb_i is high during a destination write, the masked result is appended to the queue. If src_push_i is high in the same cycle, that source word is dropped.
- R9: word_o shows the source latch when out_sel_i is 1 and the result latch when it is 0.
- R10: pix_o returns bit (15 - pix_addr_i) of the result latch, so address 0 selects the most significant bit.
- R11: Reset clears the result latch and the source latch to zero. Both latches change only on the clock edge where dst_we_i is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| ctrl_we_i | input | 1 | Load the control word |
| ctrl_data_i | input | 16 | Control word: function [15:12], left count [7:4], right count [3:0] |
| src_push_i | input | 1 | Append a source word to the queue |
| src_data_i | input | 16 | Source word to append |
| dst_we_i | input | 1 | Destination write strobe; one blend per cycle |
| dst_wb_i | input | 1 | Write the masked result back into the queue |
| dst_data_i | input | 16 | Destination word |
| lmask_en_i | input | 1 | Enable the left edge mask |
| rmask_en_i | input | 1 | Enable the right edge mask |
| line_i | input | 1 | Line-draw mode: source from pixel_i |
| pixel_i | input | 1 | Pixel value copied into every bit in line mode |
| out_sel_i | input | 1 | 1 selects the source latch on word_o, 0 selects the result latch |
| pix_addr_i | input | 4 | Pixel address for pix_o |
| word_o | output | 16 | Selected latch |
| pix_o | output | 1 | Addressed bit of the result latch |

## Verification
The hardest case to reach from the ports is a write-back that lands in the same cycle as an upstream source push. The dropped word leaves no direct trace on the outputs. The stimulus first queues one known word and then issues a write-back copy together with a push of a distinct marker value. It then queues a second marker and pops twice. The second pop must return the second marker and not the dropped word. Line mode is checked the same way: a word is queued before several line-mode writes, and the next ordinary write must still pop that word.

// File: rtl/rop_pkg.sv
// Package rop_pkg
// Shared names for the raster-op blend unit. It provides the minterm-coded
// function values used to program the unit, and the command bundle that is
// passed to the masking stage. No parameters are needed here.
package rop_pkg;

    // Function codes. Bit k enables the minterm whose {S,D} index equals k.
    typedef enum logic [3:0] {
        ROP_ZERO     = 4'h0,
        ROP_NOR      = 4'h1,
        ROP_NOT_D    = 4'h5,
        ROP_XOR      = 4'h6,
        ROP_AND      = 4'h8,
        ROP_XNOR     = 4'h9,
        ROP_PASS_D   = 4'hA,
        ROP_PASS_S   = 4'hC,
        ROP_OR       = 4'hE,
        ROP_ONES     = 4'hF
    } rop_func_e;

    // Mask enables for one destination write.
    typedef struct packed {
        logic left_en;
        logic right_en;
    } mask_cmd_t;

endpackage

// File: rtl/rop_ctrl_reg.sv
// Module rop_ctrl_reg
// Holds the control word and splits it into the function code and the two
// mask counts. The function sits in the top four bits, the left count in the
// second field from the bottom and the right count in the lowest field.
// Bits between these fields are stored nowhere.
// Assumes DATA_W >= 2*$clog2(DATA_W)+4.
module rop_ctrl_reg #(
    parameter int DATA_W = 16
) (
    input  logic                         clk_i,
    input  logic                         rst_ni,
    input  logic                         we_i,
    input  logic [DATA_W-1:0]            data_i,
    output logic [3:0]                   func_o,
    output logic [$clog2(DATA_W)-1:0]    lcnt_o,
    output logic [$clog2(DATA_W)-1:0]    rcnt_o
);
    localparam int CW = $clog2(DATA_W);

    logic [3:0]    func_q;
    logic [CW-1:0] lcnt_q;
    logic [CW-1:0] rcnt_q;

    // Load the fields on a control write; clear on reset.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            func_q <= '0;
            lcnt_q <= '0;
            rcnt_q <= '0;
        end else if (we_i) begin
            func_q <= data_i[DATA_W-1 -: 4];
            lcnt_q <= data_i[2*CW-1 : CW];
            rcnt_q <= data_i[CW-1 : 0];
        end
    end

    assign func_o = func_q;
    assign lcnt_o = lcnt_q;
    assign rcnt_o = rcnt_q;
endmodule

// File: rtl/rop_src_fifo.sv
// Module rop_src_fifo
// Circular queue of source words. The head word is always presented
// combinationally. A pop advances the head and a push writes at the tail.
// Both may happen in the same cycle. There are no full or empty guards:
// the user keeps the number of live words within DEPTH, as the surrounding
// datapath does by construction.
module rop_src_fifo #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              push_i,
    input  logic [DATA_W-1:0] push_data_i,
    input  logic              pop_i,
    output logic [DATA_W-1:0] head_o
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [AW-1:0]     head_q;
    logic [AW-1:0]     tail_q;

    // Next pointer value with wrap for any depth.
    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    // Pointer bookkeeping; both pointers start at slot zero.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            head_q <= '0;
            tail_q <= '0;
        end else begin
            if (pop_i)  head_q <= bump(head_q);
            if (push_i) tail_q <= bump(tail_q);
        end
    end

    // Storage write; the words themselves need no reset.
    always_ff @(posedge clk_i) begin
        if (push_i) mem_q[tail_q] <= push_data_i;
    end

    assign head_o = mem_q[head_q];
endmodule

// File: rtl/rop_minterm.sv
// Module rop_minterm
// Bitwise two-input Boolean function. For each bit, the pair {s,d} forms a
// two-bit index, and the function bit at that index is the output.
// This is the sum of the four enabled minterms. Purely combinational.
module rop_minterm #(
    parameter int DATA_W = 16
) (
    input  logic [3:0]        func_i,
    input  logic [DATA_W-1:0] src_i,
    input  logic [DATA_W-1:0] dst_i,
    output logic [DATA_W-1:0] res_o
);
    // One four-input selector per bit position.
    for (genvar b = 0; b < DATA_W; b++) begin : g_bit
        assign res_o[b] = func_i[{src_i[b], dst_i[b]}];
    end
endmodule

// File: rtl/rop_edge_mask.sv
// Module rop_edge_mask
// Builds the left and right edge masks from their counts and merges the raw
// result with the destination. A bit whose mask is 0 keeps the destination.
// The left mask is applied first and the right mask second. Combinational.
module rop_edge_mask
    import rop_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  mask_cmd_t                 cmd_i,
    input  logic [$clog2(DATA_W)-1:0] lcnt_i,
    input  logic [$clog2(DATA_W)-1:0] rcnt_i,
    input  logic [DATA_W-1:0]         raw_i,
    input  logic [DATA_W-1:0]         dst_i,
    output logic [DATA_W-1:0]         res_o
);
    localparam logic [DATA_W-1:0] ALL_ONES = {DATA_W{1'b1}};
    localparam logic [DATA_W-1:0] TOP_BIT  = {1'b1, {(DATA_W-1){1'b0}}};

    logic [DATA_W-1:0] left_m;
    logic [DATA_W-1:0] right_m;
    logic [DATA_W-1:0] after_left;

    // Left edge: zero-filling right shift of all ones.
    assign left_m  = ALL_ONES >> lcnt_i;
    // Right edge: sign-filling right shift of the top bit alone.
    assign right_m = DATA_W'($signed(TOP_BIT) >>> rcnt_i);

    // Apply the left mask, then the right mask, to the raw result.
    always_comb begin
        after_left = cmd_i.left_en ? ((raw_i & left_m) | (dst_i & ~left_m)) : raw_i;
        res_o      = cmd_i.right_en ? ((after_left & right_m) | (dst_i & ~right_m))
                                    : after_left;
    end
endmodule

// File: rtl/rop_blend_unit.sv
// Module rop_blend_unit
// Top of the raster-op blend unit. A destination write picks a source, which
// is the queue head or, in line mode, the replicated pixel bit. It combines
// source and destination through the programmed function, applies the edge
// masks, and latches the result. It may also append the result to the queue.
// Outside line mode the popped word is kept in the source latch.
// Assumes the caller never holds more than FIFO_DEPTH live words.
module rop_blend_unit
    import rop_pkg::*;
#(
    parameter int DATA_W     = 16,
    parameter int FIFO_DEPTH = 16
) (
    input  logic                      clk_i,
    input  logic                      rst_ni,
    input  logic                      ctrl_we_i,
    input  logic [DATA_W-1:0]         ctrl_data_i,
    input  logic                      src_push_i,
    input  logic [DATA_W-1:0]         src_data_i,
    input  logic                      dst_we_i,
    input  logic                      dst_wb_i,
    input  logic [DATA_W-1:0]         dst_data_i,
    input  logic                      lmask_en_i,
    input  logic                      rmask_en_i,
    input  logic                      line_i,
    input  logic                      pixel_i,
    input  logic                      out_sel_i,
    input  logic [$clog2(DATA_W)-1:0] pix_addr_i,
    output logic [DATA_W-1:0]         word_o,
    output logic                      pix_o
);
    localparam int CW = $clog2(DATA_W);
    localparam logic [CW-1:0] MSB_IDX = CW'(DATA_W - 1);

    logic [3:0]        func_q;
    logic [CW-1:0]     lcnt_q;
    logic [CW-1:0]     rcnt_q;
    logic [DATA_W-1:0] head_w;
    logic [DATA_W-1:0] src_w;
    logic [DATA_W-1:0] raw_w;
    logic [DATA_W-1:0] masked_w;
    logic [DATA_W-1:0] logic_q;
    logic [DATA_W-1:0] fifo_q;
    logic              pop_w;
    logic              wb_w;
    logic              push_w;
    logic [DATA_W-1:0] push_data_w;
    mask_cmd_t         mcmd_w;

    rop_ctrl_reg #(.DATA_W(DATA_W)) ctrl_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .we_i   (ctrl_we_i),
        .data_i (ctrl_data_i),
        .func_o (func_q),
        .lcnt_o (lcnt_q),
        .rcnt_o (rcnt_q)
    );

    // Queue traffic: pop on a normal blend; write-back takes the write port.
    always_comb begin
        pop_w       = dst_we_i && !line_i;
        wb_w        = dst_we_i && dst_wb_i;
        push_w      = wb_w || src_push_i;
        push_data_w = wb_w ? masked_w : src_data_i;
    end

    rop_src_fifo #(.DATA_W(DATA_W), .DEPTH(FIFO_DEPTH)) fifo_i (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .push_i      (push_w),
        .push_data_i (push_data_w),
        .pop_i       (pop_w),
        .head_o      (head_w)
    );

    // Source choice: replicated pixel in line mode, otherwise queue head.
    assign src_w = line_i ? {DATA_W{pixel_i}} : head_w;

    rop_minterm #(.DATA_W(DATA_W)) fn_i (
        .func_i (func_q),
        .src_i  (src_w),
        .dst_i  (dst_data_i),
        .res_o  (raw_w)
    );

    assign mcmd_w = '{left_en: lmask_en_i, right_en: rmask_en_i};

    rop_edge_mask #(.DATA_W(DATA_W)) mask_i (
        .cmd_i  (mcmd_w),
        .lcnt_i (lcnt_q),
        .rcnt_i (rcnt_q),
        .raw_i  (raw_w),
        .dst_i  (dst_data_i),
        .res_o  (masked_w)
    );

    // Result and source latches, written only by a destination write.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            logic_q <= '0;
            fifo_q  <= '0;
        end else if (dst_we_i) begin
            logic_q <= masked_w;
            if (!line_i) fifo_q <= head_w;
        end
    end

    // Read ports: latch selector and MSB-first pixel pick.
    assign word_o = out_sel_i ? fifo_q : logic_q;
    assign pix_o  = logic_q[MSB_IDX - pix_addr_i];
endmodule

// File: rtl/rop_blend_unit_chk.sv
// Module rop_blend_unit_chk
// Property checker for rop_blend_unit, attached by the bind at the end of
// this file. It watches the ports together with the control fields and the
// two latches. It keeps its own one-cycle copies of the destination word and
// mask counts so that edge preservation can be checked after the latch update.
module rop_blend_unit_chk #(
    parameter int DATA_W = 16
) (
    input logic                      clk_i,
    input logic                      rst_ni,
    input logic                      dst_we_i,
    input logic [DATA_W-1:0]         dst_data_i,
    input logic                      lmask_en_i,
    input logic                      rmask_en_i,
    input logic                      line_i,
    input logic                      pixel_i,
    input logic                      out_sel_i,
    input logic [$clog2(DATA_W)-1:0] pix_addr_i,
    input logic [DATA_W-1:0]         word_o,
    input logic                      pix_o,
    input logic [3:0]                func_q,
    input logic [$clog2(DATA_W)-1:0] lcnt_q,
    input logic [$clog2(DATA_W)-1:0] rcnt_q,
    input logic [DATA_W-1:0]         logic_q,
    input logic [DATA_W-1:0]         fifo_q
);
    localparam int CW = $clog2(DATA_W);

    logic [DATA_W-1:0] dst_prev;
    logic [CW-1:0]     lcnt_prev;
    logic [CW-1:0]     rcnt_prev;
    logic [DATA_W-1:0] diff_w;
    logic [DATA_W-1:0] left_out_w;
    logic [DATA_W-1:0] right_out_w;

    // One-cycle copies of the write operands.
    always_ff @(posedge clk_i) begin
        dst_prev  <= dst_data_i;
        lcnt_prev <= lcnt_q;
        rcnt_prev <= rcnt_q;
    end

    // Difference between the latched result and last cycle's destination.
    assign diff_w      = logic_q ^ dst_prev;
    assign left_out_w  = diff_w >> (DATA_W - int'(lcnt_prev));
    assign right_out_w = diff_w << (int'(rcnt_prev) + 1);

    assert_reset_clear_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(rst_ni) |-> (logic_q == '0) && (fifo_q == '0));

    assert_hold_idle_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !dst_we_i |=> $stable(logic_q) && $stable(fifo_q));

    assert_line_no_pop_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        dst_we_i && line_i |=> $stable(fifo_q));

    assert_line_fill_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        dst_we_i && line_i && func_q == 4'hC && !lmask_en_i && !rmask_en_i
        |=> logic_q == {DATA_W{$past(pixel_i)}});

    assert_func_zero_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        dst_we_i && func_q == 4'h0 && !lmask_en_i && !rmask_en_i |=> logic_q == '0);

    assert_left_keep_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        dst_we_i && lmask_en_i |=> left_out_w == '0);

    assert_right_keep_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        dst_we_i && rmask_en_i |=> right_out_w == '0);

    assert_pixel_port_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !out_sel_i |-> pix_o == word_o[DATA_W-1-int'(pix_addr_i)]);
endmodule

bind rop_blend_unit rop_blend_unit_chk #(.DATA_W(DATA_W)) chk_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .dst_we_i   (dst_we_i),
    .dst_data_i (dst_data_i),
    .lmask_en_i (lmask_en_i),
    .rmask_en_i (rmask_en_i),
    .line_i     (line_i),
    .pixel_i    (pixel_i),
    .out_sel_i  (out_sel_i),
    .pix_addr_i (pix_addr_i),
    .word_o     (word_o),
    .pix_o      (pix_o),
    .func_q     (func_q),
    .lcnt_q     (lcnt_q),
    .rcnt_q     (rcnt_q),
    .logic_q    (logic_q),
    .fifo_q     (fifo_q)
);

// File: tb/rop_blend_unit_tb_top.sv
// Scoreboard bench for rop_blend_unit. Driver tasks update a bench-side model
// written from the requirements and queue the expected read-port values.
// A monitor at the falling edge pops each item and compares it with the ports.
module rop_blend_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctrl_we = 1'b0;
    logic [15:0] ctrl_data = '0;
    logic        src_push = 1'b0;
    logic [15:0] src_data = '0;
    logic        dst_we = 1'b0;
    logic        dst_wb = 1'b0;
    logic [15:0] dst_data = '0;
    logic        lm_en = 1'b0;
    logic        rm_en = 1'b0;
    logic        line = 1'b0;
    logic        pixel = 1'b0;
    logic        out_sel = 1'b0;
    logic [3:0]  pix_addr = '0;
    logic [15:0] word;
    logic        pix;

    always #4 clk = ~clk;

    rop_blend_unit dut_i (
        .clk_i (clk), .rst_ni (rst_n), .ctrl_we_i (ctrl_we), .ctrl_data_i (ctrl_data),
        .src_push_i (src_push), .src_data_i (src_data), .dst_we_i (dst_we),
        .dst_wb_i (dst_wb), .dst_data_i (dst_data), .lmask_en_i (lm_en),
        .rmask_en_i (rm_en), .line_i (line), .pixel_i (pixel), .out_sel_i (out_sel),
        .pix_addr_i (pix_addr), .word_o (word), .pix_o (pix)
    );

    typedef struct {
        logic [15:0] word;
        logic        pix;
        string       tag;
    } exp_t;

    exp_t        exp_q[$];
    logic [15:0] mdl_q[$];
    logic [15:0] mdl_res = '0;
    logic [15:0] mdl_src = '0;
    logic [3:0]  m_func = '0;
    logic [3:0]  m_l = '0;
    logic [3:0]  m_r = '0;
    int          errors = 0;
    int          checks = 0;

    // R1 model: OR of the four enabled minterms.
    function automatic logic [15:0] mdl_rop(input logic [3:0] f, input logic [15:0] s,
                                            input logic [15:0] d);
        return ({16{f[3]}} & s & d) | ({16{f[2]}} & s & ~d) |
               ({16{f[1]}} & ~s & d) | ({16{f[0]}} & ~s & ~d);
    endfunction

    // R6 model: ones from bit 15 down to bit 15-r.
    function automatic logic [15:0] mdl_rmask(input logic [3:0] r);
        logic [15:0] m = '0;
        for (int i = 0; i <= 15; i++) if (i <= int'(r)) m[15-i] = 1'b1;
        return m;
    endfunction

    task automatic ctrl_wr(input logic [15:0] v);
        ctrl_we = 1'b1; ctrl_data = v;
        @(posedge clk); #1;
        ctrl_we = 1'b0;
        m_func = v[15:12]; m_l = v[7:4]; m_r = v[3:0];
    endtask

    task automatic push(input logic [15:0] v);
        src_push = 1'b1; src_data = v;
        @(posedge clk); #1;
        src_push = 1'b0;
        mdl_q.push_back(v);
    endtask

    // One destination write; optional simultaneous source push.
    task automatic blend(input logic [15:0] d, input logic wb, input logic le,
                         input logic re, input logic ln, input logic px,
                         input logic sp, input logic [15:0] sv);
        logic [15:0] s;
        logic [15:0] r;
        logic [15:0] lmk;
        logic [15:0] rmk;
        dst_we = 1'b1; dst_data = d; dst_wb = wb; lm_en = le; rm_en = re;
        line = ln; pixel = px; src_push = sp; src_data = sv;
        @(posedge clk); #1;
        dst_we = 1'b0; dst_wb = 1'b0; lm_en = 1'b0; rm_en = 1'b0;
        line = 1'b0; pixel = 1'b0; src_push = 1'b0;
        if (ln) s = px ? 16'hFFFF : 16'h0000;
        else begin
            s = mdl_q.pop_front();
            mdl_src = s;
        end
        r = mdl_rop(m_func, s, d);
        lmk = 16'hFFFF >> m_l;
        rmk = mdl_rmask(m_r);
        if (le) r = (r & lmk) | (d & ~lmk);
        if (re) r = (r & rmk) | (d & ~rmk);
        mdl_res = r;
        if (wb) mdl_q.push_back(r);
        else if (sp) mdl_q.push_back(sv);
    endtask

    // Queue one expected read for the monitor.
    task automatic expect_rd(input logic sel, input logic [3:0] a, input string tag);
        exp_t e;
        out_sel = sel; pix_addr = a;
        e.word = sel ? mdl_src : mdl_res;
        e.pix  = mdl_res[15 - int'(a)];
        e.tag  = tag;
        exp_q.push_back(e);
        @(posedge clk); #1;
    endtask

    // Monitor: compare at the falling edge.
    always @(negedge clk) begin
        exp_t e;
        if (exp_q.size() != 0) begin
            e = exp_q.pop_front();
            checks += 2;
            if (word !== e.word) begin
                errors++;
                $display("FAIL %s word actual=%h expected=%h", e.tag, word, e.word);
            end
            if (pix !== e.pix) begin
                errors++;
                $display("FAIL %s pix actual=%b expected=%b", e.tag, pix, e.pix);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL R11 watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R11 reset state of both latches
        expect_rd(1'b0, 4'd0, "R11 reset result");
        expect_rd(1'b1, 4'd5, "R11 reset source");

        // R1 copy source; R3 pop captured; R9 both latches
        ctrl_wr(16'hC000);
        push(16'hA5A5);
        blend(16'h0F0F, 0, 0, 0, 0, 0, 0, 16'h0);
        expect_rd(1'b0, 4'd0, "R1 copy");
        expect_rd(1'b1, 4'd1, "R9 source latch");
        // R11 latches hold across idle cycles and a control write
        ctrl_wr(16'h6000);
        expect_rd(1'b0, 4'd2, "R11 hold");

        // R1 several functions
        for (int k = 0; k < 6; k++) begin
            logic [3:0] fl [6];
            fl = '{4'h6, 4'h8, 4'hE, 4'h1, 4'h9, 4'hA};
            ctrl_wr({fl[k], 12'h000});
            push(16'hFF00 ^ 16'(k * 16'h1111));
            blend(16'h0FF0, 0, 0, 0, 0, 0, 0, 16'h0);
            expect_rd(1'b0, 4'(k), "R1 function");
        end

        // R2 bits 11:8 ignored
        ctrl_wr(16'hCF00);
        push(16'h3C3C);
        blend(16'h1234, 0, 0, 0, 0, 0, 0, 16'h0);
        expect_rd(1'b0, 4'd3, "R2 middle bits ignored");

        // R3 order of pops
        push(16'h1001); push(16'h2002); push(16'h3003);
        for (int k = 0; k < 3; k++) begin
            blend(16'hFFFF, 0, 0, 0, 0, 0, 0, 16'h0);
            expect_rd(1'b1, 4'd0, "R3 order");
        end

        // R4 line mode: replicated pixel, no pop
        push(16'h5A5A);
        blend(16'h0000, 0, 0, 0, 1, 1, 0, 16'h0);
        expect_rd(1'b0, 4'd9, "R4 pixel high");
        expect_rd(1'b1, 4'd0, "R4 source latch kept");
        blend(16'hFFFF, 0, 0, 0, 1, 0, 0, 16'h0);
        expect_rd(1'b0, 4'd9, "R4 pixel low");
        blend(16'h0000, 0, 0, 0, 0, 0, 0, 16'h0);
        expect_rd(1'b1, 4'd0, "R4 queued word intact");

        // R5 left mask
        ctrl_wr(16'hF040);
        push(16'h0);
        blend(16'h1234, 0, 1, 0, 0, 0, 0, 16'h0);
        expect_rd(1'b0, 4'd3, "R5 left count 4");
        ctrl_wr(16'hF000);
        push(16'h0);
        blend(16'h1234, 0, 1, 0, 0, 0, 0, 16'h0);
        expect_rd(1'b0, 4'd3, "R5 left count 0");
        // R6 right mask
        ctrl_wr(16'hF003);
        push(16'h0);
        blend(16'h1234, 0, 0, 1, 0, 0, 0, 16'h0);
        expect_rd(1'b0, 4'd4, "R6 right count 3");
        ctrl_wr(16'hF00F);
        push(16'h0);
        blend(16'h1234, 0, 0, 1, 0, 0, 0, 16'h0);
        expect_rd(1'b0, 4'd15, "R6 right count 15");
        // R5 R6 counts without enables have no effect
        ctrl_wr(16'hF0FF);
        push(16'h0);
        blend(16'h1234, 0, 0, 0, 0, 0, 0, 16'h0);
        expect_rd(1'b0, 4'd7, "R5 R6 disabled masks");
        // R7 both masks
        ctrl_wr(16'hF047);
        push(16'h0);
        blend(16'h0000, 0, 1, 1, 0, 0, 0, 16'h0);
        expect_rd(1'b0, 4'd4, "R7 both masks");
        expect_rd(1'b0, 4'd3, "R7 both masks edge");

        // R8 write-back then pop of written word
        ctrl_wr(16'h5000);
        push(16'hAAAA);
        blend(16'h00FF, 1, 0, 0, 0, 0, 0, 16'h0);
        expect_rd(1'b0, 4'd0, "R8 write-back result");
        ctrl_wr(16'hC000);
        blend(16'h0000, 0, 0, 0, 0, 0, 0, 16'h0);
        expect_rd(1'b1, 4'd0, "R8 written word popped");
        // R8 write-back wins over a same-cycle push
        push(16'h1111);
        blend(16'h2222, 1, 0, 0, 0, 0, 1, 16'h9999);
        push(16'h7777);
        blend(16'h0000, 0, 0, 0, 0, 0, 0, 16'h0);
        expect_rd(1'b1, 4'd0, "R8 write-back word");
        blend(16'h0000, 0, 0, 0, 0, 0, 0, 16'h0);
        expect_rd(1'b1, 4'd0, "R8 push dropped");

        // R10 pixel addressing, MSB first
        push(16'h8001);
        blend(16'h0000, 0, 0, 0, 0, 0, 0, 16'h0);
        for (int a = 0; a < 16; a += 5) expect_rd(1'b0, 4'(a), "R10 pixel");
        expect_rd(1'b0, 4'd15, "R10 pixel lsb");
        expect_rd(1'b1, 4'd1, "R9 select source");

        @(posedge clk); #1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule